// File: doc/BRIEF.md
# SMART Command Decode and Status Unit

This block sits behind a byte-wide task-file register port of a storage device controller. The host writes a subcommand byte, two signature bytes and a device-select byte into shadow registers. It then writes the command opcode. If the device-select bit matches the device's own strap, the unit starts the command. It raises the busy bit for a fixed number of cycles. It then posts a completion pattern or an abort pattern in the status and error bytes.

The unit validates the two signature bytes and classifies the subcommand byte as supported, obsolete, reserved or vendor specific. It keeps a single monitoring-enabled flag. Two subcommands turn this flag on and off. Data-transfer subcommands are only recognised and reported as accepted. The unit moves no data.

Top module: `smart_cmd_unit`

## Requirements
- R1: After reset, the status byte reads 40h, the error byte reads 00h and the monitoring flag is 1.
- R2: A command write that is accepted (register select 4, the unit not busy, device byte bit 4 equal to `dev_strap`) makes the status byte read exactly 80h. This starts on the next cycle and lasts BUSY_CYCLES cycles. After that the result is posted.
- R3: The command aborts unless the signature low byte (select 1) is 4Fh and the signature high byte (select 2) is C2h. An abort posts status 41h (DRDY bit 6 and ERR bit 0 set, BSY bit 7, DF bit 5 and DRQ bit 3 clear) and error 04h (ABRT bit 2).
- R4: A successful command posts status 40h and error 00h.
- R5: When monitoring is enabled, subcommands D0h, D2h, D4h, D5h, D6h, DAh and the vendor range E0h–FFh succeed. The obsolete codes D1h, D3h, D7h and DBh abort. The reserved ranges 00h–CFh and DCh–DFh also abort.
- R6: Subcommand D9h succeeds and clears the monitoring flag. Subcommand D8h succeeds and sets the flag, even when the flag is clear. The flag changes only in the cycle in which the result is posted.
- R7: While monitoring is disabled, every subcommand except D8h aborts and leaves the flag clear.
- R8: A command write whose latched device bit differs from `dev_strap` is ignored. It causes no busy period, and the status, error and flag keep their values.
- R9: While busy, all register writes are ignored. A second command write does not restart or extend the busy period, and the shadow bytes keep their earlier values.
- R10: An opcode other than B0h aborts, even with a valid signature and subcommand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select: 0 subcommand, 1 signature low, 2 signature high, 3 device, 4 command |
| wr_data | input | 8 | Write data byte |
| dev_strap | input | 1 | This device's select value, compared with device byte bit 4 |
| status_o | output | 8 | Status byte (BSY 7, DRDY 6, DF 5, DRQ 3, ERR 0) |
| error_o | output | 8 | Error byte (ABRT 2) |
| smart_on_o | output | 1 | Monitoring-enabled flag |

## Verification
The assertions assume that the host keeps `dev_strap` steady and writes only with defined select and data values. They also assume the host makes at most one write per cycle. The bench holds the strap at 1 for the whole run and drives every write for a single cycle on the falling edge. It does not wait for the busy bit to clear before its deliberate mid-command writes. This exercises the write lockout within those same assumptions.

// File: rtl/smart_pkg.sv
package smart_pkg;
    localparam logic [7:0] OP_SMART = 8'hB0;
    localparam logic [7:0] SIG_LO   = 8'h4F;
    localparam logic [7:0] SIG_HI   = 8'hC2;
    localparam logic [7:0] SUB_ON   = 8'hD8;
    localparam logic [7:0] SUB_OFF  = 8'hD9;

    localparam int ST_BSY  = 7;
    localparam int ST_DRDY = 6;
    localparam int ST_DF   = 5;
    localparam int ST_DRQ  = 3;
    localparam int ST_ERR  = 0;
    localparam int ER_ABRT = 2;
    localparam int DEV_BIT = 4;

    localparam int NUM_SHADOW = 3;

    typedef enum logic [2:0] {
        SEL_SUB  = 3'd0,
        SEL_SLO  = 3'd1,
        SEL_SHI  = 3'd2,
        SEL_DEV  = 3'd3,
        SEL_CMD  = 3'd4
    } tf_sel_e;

    typedef enum logic [1:0] {
        CLS_RESERVED,
        CLS_OBSOLETE,
        CLS_SUPPORTED,
        CLS_VENDOR
    } sub_cls_e;

    function automatic sub_cls_e classify(input logic [7:0] code);
        sub_cls_e c;
        if (code >= 8'hE0)
            c = CLS_VENDOR;
        else if (code < 8'hD0 || code > 8'hDB)
            c = CLS_RESERVED;
        else if (code == 8'hD1 || code == 8'hD3 || code == 8'hD7 || code == 8'hDB)
            c = CLS_OBSOLETE;
        else
            c = CLS_SUPPORTED;
        return c;
    endfunction
endpackage

// File: rtl/smart_tf_shadow.sv
module smart_tf_shadow
    import smart_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] wr_sel,
    input  logic [7:0] wr_data,
    input  logic       lock,
    output logic [7:0] sub_q,
    output logic [7:0] sig_lo_q,
    output logic [7:0] sig_hi_q,
    output logic       dev_q
);
    typedef struct packed {
        logic [NUM_SHADOW-1:0][7:0] bytes;
        logic                       dev;
    } shadow_t;

    shadow_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en && !lock) begin
            for (int i = 0; i < NUM_SHADOW; i++) begin
                if (wr_sel == 3'(i))
                    s_d.bytes[i] = wr_data;
            end
            if (wr_sel == SEL_DEV)
                s_d.dev = wr_data[DEV_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign sub_q    = s_q.bytes[SEL_SUB];
    assign sig_lo_q = s_q.bytes[SEL_SLO];
    assign sig_hi_q = s_q.bytes[SEL_SHI];
    assign dev_q    = s_q.dev;
endmodule

// File: rtl/smart_subcmd_decode.sv
module smart_subcmd_decode
    import smart_pkg::*;
(
    input  logic [7:0] opcode,
    input  logic [7:0] sub,
    input  logic [7:0] sig_lo,
    input  logic [7:0] sig_hi,
    input  logic       on_now,
    output logic       abort,
    output logic       on_next
);
    logic     sig_ok;
    sub_cls_e cls;

    assign sig_ok = (sig_lo == SIG_LO) && (sig_hi == SIG_HI);
    assign cls    = classify(sub);

    always_comb begin
        abort   = 1'b0;
        on_next = on_now;
        if (opcode != OP_SMART || !sig_ok) begin
            abort = 1'b1;
        end else if (sub == SUB_ON) begin
            on_next = 1'b1;
        end else if (!on_now) begin
            abort = 1'b1;
        end else if (cls == CLS_RESERVED || cls == CLS_OBSOLETE) begin
            abort = 1'b1;
        end else if (sub == SUB_OFF) begin
            on_next = 1'b0;
        end
    end
endmodule

// File: rtl/smart_cmd_unit.sv
module smart_cmd_unit
    import smart_pkg::*;
#(
    parameter int BUSY_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] wr_sel,
    input  logic [7:0] wr_data,
    input  logic       dev_strap,
    output logic [7:0] status_o,
    output logic [7:0] error_o,
    output logic       smart_on_o
);
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYCLES - 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic [7:0]       status;
        logic [7:0]       error;
        logic             on;
        logic             pend_abort;
        logic             pend_on;
    } unit_t;

    unit_t u_d, u_q;

    logic [7:0] sub_q, sig_lo_q, sig_hi_q;
    logic       dev_q;
    logic       dec_abort, dec_on;
    logic       start;

    smart_tf_shadow u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .lock     (u_q.busy),
        .sub_q    (sub_q),
        .sig_lo_q (sig_lo_q),
        .sig_hi_q (sig_hi_q),
        .dev_q    (dev_q)
    );

    smart_subcmd_decode u_dec (
        .opcode  (wr_data),
        .sub     (sub_q),
        .sig_lo  (sig_lo_q),
        .sig_hi  (sig_hi_q),
        .on_now  (u_q.on),
        .abort   (dec_abort),
        .on_next (dec_on)
    );

    assign start = wr_en && (wr_sel == SEL_CMD) && !u_q.busy && (dev_q == dev_strap);

    always_comb begin
        u_d = u_q;
        if (start) begin
            u_d.busy              = 1'b1;
            u_d.cnt               = CNT_LOAD;
            u_d.status            = '0;
            u_d.status[ST_BSY]    = 1'b1;
            u_d.error             = '0;
            u_d.pend_abort        = dec_abort;
            u_d.pend_on           = dec_on;
        end else if (u_q.busy) begin
            if (u_q.cnt == '0) begin
                u_d.busy             = 1'b0;
                u_d.status           = '0;
                u_d.status[ST_DRDY]  = 1'b1;
                u_d.status[ST_ERR]   = u_q.pend_abort;
                u_d.error            = '0;
                u_d.error[ER_ABRT]   = u_q.pend_abort;
                u_d.on               = u_q.pend_on;
            end else begin
                u_d.cnt = u_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            u_q                  <= '0;
            u_q.status[ST_DRDY]  <= 1'b1;
            u_q.on               <= 1'b1;
            u_q.pend_on          <= 1'b1;
        end else begin
            u_q <= u_d;
        end
    end

    assign status_o   = u_q.status;
    assign error_o    = u_q.error;
    assign smart_on_o = u_q.on;
endmodule

// File: rtl/smart_cmd_unit_chk.sv
module smart_cmd_unit_chk
    import smart_pkg::*;
#(
    parameter int BUSY_CYCLES = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [2:0] wr_sel,
    input logic       dev_wr_bit,
    input logic       dev_strap,
    input logic [7:0] status_o,
    input logic [7:0] error_o,
    input logic       smart_on_o
);
    localparam int CW = $clog2(BUSY_CYCLES + 2);

    logic [CW-1:0] busy_cnt_q;
    logic          dev_m_q;
    logic          bsy;
    logic          cmd_wr;

    assign bsy    = status_o[ST_BSY];
    assign cmd_wr = wr_en && (wr_sel == SEL_CMD) && !bsy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_cnt_q <= '0;
            dev_m_q    <= 1'b0;
        end else begin
            busy_cnt_q <= bsy ? busy_cnt_q + 1'b1 : '0;
            if (wr_en && wr_sel == SEL_DEV && !bsy)
                dev_m_q <= dev_wr_bit;
        end
    end

    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && (dev_m_q == dev_strap) |=> status_o == 8'h80);

    assert_busy_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bsy |-> busy_cnt_q < CW'(BUSY_CYCLES));

    assert_busy_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bsy) |-> $past(busy_cnt_q) == CW'(BUSY_CYCLES - 1));

    assert_idle_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !bsy |-> status_o[ST_DRDY] && !status_o[ST_DF] && !status_o[ST_DRQ]);

    assert_abort_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !bsy |-> (status_o[ST_ERR] == error_o[ER_ABRT]));

    assert_flag_at_post_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(smart_on_o) |-> $fell(bsy));

    assert_strap_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && (dev_m_q != dev_strap) |=> $stable(status_o) && $stable(error_o));
endmodule

bind smart_cmd_unit smart_cmd_unit_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .dev_wr_bit (wr_data[4]),
    .dev_strap  (dev_strap),
    .status_o   (status_o),
    .error_o    (error_o),
    .smart_on_o (smart_on_o)
);

// File: tb/smart_cmd_unit_test.sv
`timescale 1ns/1ps
module smart_cmd_unit_test;
    localparam int BUSY_CYCLES = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic       dev_strap = 1'b1;
    logic [7:0] status_o, error_o;
    logic       smart_on_o;

    int checks = 0;
    int errors = 0;
    int rises = 0;
    int cycles = 0;
    bit model_on = 1'b1;

    logic [16:0] exp_q[$];
    string       tag_q[$];

    smart_cmd_unit #(.BUSY_CYCLES(BUSY_CYCLES)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .dev_strap(dev_strap),
        .status_o(status_o), .error_o(error_o), .smart_on_o(smart_on_o)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Expected outcome from the requirements: {abort, new flag}
    function automatic logic [1:0] predict(input logic [7:0] op, input logic [7:0] sub,
                                           input logic [7:0] lo, input logic [7:0] hi,
                                           input bit on);
        bit bad_code;
        bad_code = (sub < 8'hD0) || (sub >= 8'hDC && sub <= 8'hDF) ||
                   sub == 8'hD1 || sub == 8'hD3 || sub == 8'hD7 || sub == 8'hDB;
        if (op != 8'hB0 || lo != 8'h4F || hi != 8'hC2) return {1'b1, on};  // R3, R10
        if (sub == 8'hD8) return {1'b0, 1'b1};                              // R6
        if (!on) return {1'b1, 1'b0};                                       // R7
        if (bad_code) return {1'b1, on};                                    // R5
        if (sub == 8'hD9) return {1'b0, 1'b0};                              // R6
        return {1'b0, on};                                                  // R4
    endfunction

    task automatic wr(input logic [2:0] s, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic push_exp(input string tag, input logic [7:0] op, input logic [7:0] sub,
                            input logic [7:0] lo, input logic [7:0] hi);
        logic [1:0] r;
        r = predict(op, sub, lo, hi, model_on);
        model_on = r[0];
        exp_q.push_back({r[1] ? 8'h41 : 8'h40, r[1] ? 8'h04 : 8'h00, r[0]});
        tag_q.push_back(tag);
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (exp_q.size() != 0);
    endtask

    task automatic issue(input string tag, input logic [7:0] sub, input logic [7:0] lo,
                         input logic [7:0] hi, input logic [7:0] op);
        wr(3'd0, sub); wr(3'd1, lo); wr(3'd2, hi); wr(3'd3, 8'hB0);
        push_exp(tag, op, sub, lo, hi);
        wr(3'd4, op);
        wait_idle();
    endtask

    // Monitor: scoreboard pop at each end of a busy period
    int  busy_len = 0;
    bit  prev_bsy = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (status_o[7]) begin
                if (!prev_bsy) rises++;
                busy_len++;
                check("R2 busy pattern", status_o, 8'h80);
            end else if (prev_bsy) begin
                if (exp_q.size() == 0) begin
                    check("R9 unexpected completion", 1, 0);
                end else begin
                    logic [16:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check({t, " status"}, status_o, e[16:9]);
                    check({t, " error"}, error_o, e[8:1]);
                    check({t, " flag"}, smart_on_o, e[0]);
                    check("R2 busy length", busy_len, BUSY_CYCLES);
                end
                busy_len = 0;
            end
            prev_bsy = status_o[7];
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                check("watchdog", 0, 1);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        int r0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 status", status_o, 8'h40);
        check("R1 error", error_o, 8'h00);
        check("R1 flag", smart_on_o, 1);

        issue("R4 D0", 8'hD0, 8'h4F, 8'hC2, 8'hB0);
        issue("R5 D2", 8'hD2, 8'h4F, 8'hC2, 8'hB0);
        issue("R5 D4", 8'hD4, 8'h4F, 8'hC2, 8'hB0);
        issue("R5 D5", 8'hD5, 8'h4F, 8'hC2, 8'hB0);
        issue("R5 D6", 8'hD6, 8'h4F, 8'hC2, 8'hB0);
        issue("R5 DA", 8'hDA, 8'h4F, 8'hC2, 8'hB0);
        issue("R5 vendor E0", 8'hE0, 8'h4F, 8'hC2, 8'hB0);
        issue("R5 vendor FF", 8'hFF, 8'h4F, 8'hC2, 8'hB0);
        issue("R5 obsolete D1", 8'hD1, 8'h4F, 8'hC2, 8'hB0);
        issue("R5 obsolete D7", 8'hD7, 8'h4F, 8'hC2, 8'hB0);
        issue("R5 obsolete DB", 8'hDB, 8'h4F, 8'hC2, 8'hB0);
        issue("R4 clears error", 8'hD0, 8'h4F, 8'hC2, 8'hB0);
        issue("R5 reserved 00", 8'h00, 8'h4F, 8'hC2, 8'hB0);
        issue("R5 reserved CF", 8'hCF, 8'h4F, 8'hC2, 8'hB0);
        issue("R5 reserved DC", 8'hDC, 8'h4F, 8'hC2, 8'hB0);
        issue("R5 reserved DF", 8'hDF, 8'h4F, 8'hC2, 8'hB0);
        issue("R3 bad low", 8'hD0, 8'h4E, 8'hC2, 8'hB0);
        issue("R3 bad high", 8'hD0, 8'h4F, 8'hC3, 8'hB0);
        issue("R3 swapped", 8'hD0, 8'hC2, 8'h4F, 8'hB0);
        issue("R10 other opcode", 8'hD0, 8'h4F, 8'hC2, 8'hEC);

        issue("R6 disable", 8'hD9, 8'h4F, 8'hC2, 8'hB0);
        issue("R7 D0 while off", 8'hD0, 8'h4F, 8'hC2, 8'hB0);
        issue("R7 D9 while off", 8'hD9, 8'h4F, 8'hC2, 8'hB0);
        issue("R7 vendor while off", 8'hE0, 8'h4F, 8'hC2, 8'hB0);
        issue("R6 enable", 8'hD8, 8'h4F, 8'hC2, 8'hB0);
        issue("R6 D0 after enable", 8'hD0, 8'h4F, 8'hC2, 8'hB0);

        // R8: device bit mismatch, then an abort-worthy opcode that must not run
        r0 = rises;
        wr(3'd3, 8'hA0);
        wr(3'd4, 8'hEC);
        repeat (BUSY_CYCLES + 4) @(negedge clk);
        check("R8 no busy", rises - r0, 0);
        check("R8 status kept", status_o, 8'h40);
        check("R8 error kept", error_o, 8'h00);
        check("R8 flag kept", smart_on_o, 1);

        // R9: writes during busy are dropped
        wr(3'd3, 8'hB0);
        r0 = rises;
        push_exp("R9 first", 8'hB0, 8'hD0, 8'h4F, 8'hC2);
        wr(3'd4, 8'hB0);
        wr(3'd1, 8'h00);
        wr(3'd4, 8'hB0);
        wait_idle();
        repeat (BUSY_CYCLES + 4) @(negedge clk);
        check("R9 single busy period", rises - r0, 1);
        push_exp("R9 signature kept", 8'hB0, 8'hD0, 8'h4F, 8'hC2);
        wr(3'd4, 8'hB0);
        wait_idle();

        repeat (4) @(negedge clk);
        check("R9 queue drained", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule